// File: doc/BRIEF.md
# Flag-Configurable Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit for two 16-bit operands. It has no opcode decoder. A six-bit control word steers one fixed datapath. First each operand is conditioned: it may be forced to zero, then bit-inverted. Next a single stage forms either the bitwise AND or the two's-complement sum of the two conditioned operands. Last, the chosen value may be inverted again before it leaves the block.

Sums, bitwise AND and OR, negation, increments, differences and small constants all come from different settings of the same six bits. Two status flags go with the result: one reports an all-zero result and one reports a negative result. A surrounding sequencer registers the outputs in its own pipeline stage, so the block holds no state.

Top module: `flag_alu`

## Requirements
- R1: Control bit 5 forces the x operand to zero and bit 4 inverts it. The clear is applied before the invert, so setting both gives an all-ones x.
- R2: Control bit 3 forces the y operand to zero and bit 2 inverts it. The clear is applied before the invert, so setting both gives an all-ones y.
- R3: Control bit 1 set selects the sum of the conditioned operands. Control bit 1 clear selects their bitwise AND.
- R4: Control bit 0 set inverts every bit of the selected value before output.
- R5: The negative flag equals bit 15 of the result.
- R6: The zero flag is 1 exactly when all 16 result bits are 0.
- R7: Addition wraps modulo 2^16 with no overflow indication. For example, 0x7FFF plus 1 gives 0x8000 with the negative flag set.
- R8: Derived functions come from fixed control words:
  - 000010 gives x+y
  - 000000 gives x AND y
  - 010101 gives x OR y
  - 001111 gives -x
  - 011111 gives x+1
  - 000111 gives y-x
- R9: Operand-free constants come from fixed control words: 101010 gives 0, 111111 gives 1, and 111010 gives 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_x | input | 16 | First data operand |
| op_y | input | 16 | Second data operand |
| ctl | input | 6 | Control word, bit 5 down to 0: clear x, invert x, clear y, invert y, add select, invert output |
| result | output | 16 | Final result |
| is_zero | output | 1 | Result is all zeros |
| is_neg | output | 1 | Result bit 15 |

## Verification
The hardest case to reach from the ports is a carry that runs through all 16 bits and the sign change this causes. Random operands seldom produce it. The stimulus therefore pairs the corner operands 0, 0xFFFF, 0x8000 and 0x7FFF with every derived control word. It also drives all 64 control words over those corners, so that the clear-before-invert ordering and the carry out of bit 15 (which must be dropped) are both exercised. Random operands then cover the general case.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int DATA_W = 16;

    // Control word layout, most significant bit first
    typedef struct packed {
        logic clr_x;
        logic inv_x;
        logic clr_y;
        logic inv_y;
        logic sel_add;
        logic inv_out;
    } alu_ctl_t;

    localparam int CTL_W = $bits(alu_ctl_t);

    // Per-operand conditioning request
    typedef struct packed {
        logic clr;
        logic inv;
    } cond_req_t;

    function automatic cond_req_t x_req(input alu_ctl_t c);
        cond_req_t r;
        r.clr = c.clr_x;
        r.inv = c.inv_x;
        return r;
    endfunction

    function automatic cond_req_t y_req(input alu_ctl_t c);
        cond_req_t r;
        r.clr = c.clr_y;
        r.inv = c.inv_y;
        return r;
    endfunction

endpackage

// File: rtl/alu_precond.sv
module alu_precond
    import alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] din,
    input  cond_req_t    req,
    output logic [W-1:0] dout
);
    logic [W-1:0] cleared;

    always_comb begin
        cleared = req.clr ? '0 : din;
        dout    = req.inv ? ~cleared : cleared;
    end
endmodule

// File: rtl/alu_core.sv
module alu_core #(
    parameter int W          = 16,
    parameter bit USE_RIPPLE = 1'b1
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sel_add,
    input  logic         inv_out,
    output logic [W-1:0] y
);
    logic [W-1:0] sum;
    logic [W-1:0] conj;

    assign conj = a & b;

    generate
        if (USE_RIPPLE) begin : g_ripple
            logic [W:0] cy;
            assign cy[0] = 1'b0;
            for (genvar i = 0; i < W; i++) begin : g_bit
                logic p;
                assign p        = a[i] ^ b[i];
                assign sum[i]   = p ^ cy[i];
                assign cy[i+1]  = (a[i] & b[i]) | (cy[i] & p);
            end
        end else begin : g_behav
            assign sum = a + b;
        end
    endgenerate

    logic [W-1:0] pick;
    always_comb begin
        pick = sel_add ? sum : conj;
        y    = inv_out ? ~pick : pick;
    end
endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
    parameter int W = 16
) (
    input  logic [W-1:0] val,
    output logic         zero,
    output logic         neg
);
    assign zero = ~(|val);
    assign neg  = val[W-1];
endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import alu_pkg::*;
#(
    parameter int W          = DATA_W,
    parameter bit USE_RIPPLE = 1'b1
) (
    input  logic [W-1:0]     op_x,
    input  logic [W-1:0]     op_y,
    input  logic [CTL_W-1:0] ctl,
    output logic [W-1:0]     result,
    output logic             is_zero,
    output logic             is_neg
);
    localparam int NOPS = 2;

    alu_ctl_t     c;
    logic [W-1:0] raw [NOPS];
    logic [W-1:0] cnd [NOPS];
    cond_req_t    req [NOPS];

    assign c      = alu_ctl_t'(ctl);
    assign raw[0] = op_x;
    assign raw[1] = op_y;
    assign req[0] = x_req(c);
    assign req[1] = y_req(c);

    generate
        for (genvar k = 0; k < NOPS; k++) begin : g_cond
            alu_precond #(.W(W)) u_pc (
                .din  (raw[k]),
                .req  (req[k]),
                .dout (cnd[k])
            );
        end
    endgenerate

    alu_core #(.W(W), .USE_RIPPLE(USE_RIPPLE)) u_core (
        .a       (cnd[0]),
        .b       (cnd[1]),
        .sel_add (c.sel_add),
        .inv_out (c.inv_out),
        .y       (result)
    );

    alu_flags #(.W(W)) u_flags (
        .val  (result),
        .zero (is_zero),
        .neg  (is_neg)
    );
endmodule

// File: rtl/alu_props.sv
module alu_props #(
    parameter int W = 16
) (
    input logic [W-1:0] op_x,
    input logic [W-1:0] op_y,
    input logic [5:0]   ctl,
    input logic [W-1:0] result,
    input logic         is_zero,
    input logic         is_neg
);
    always_comb begin
        AST_NEG_IS_MSB: assert (is_neg == result[W-1]);                       // R5
        AST_ZERO_EXACT: assert (is_zero == (result == '0));                   // R6
        if (ctl == 6'b110000)
            AST_X_ALL_ONES: assert (result == op_y);                          // R1
        if (ctl == 6'b001100)
            AST_Y_ALL_ONES: assert (result == op_x);                          // R2
        if (ctl == 6'b101010)
            AST_CONST_ZERO: assert (result == '0 && is_zero);                 // R9
        if (ctl == 6'b101011)
            AST_INV_OF_ZERO: assert (result == '1 && is_neg);                 // R4
        if (ctl == 6'b000010 && op_x == {1'b0, {(W-1){1'b1}}} && op_y == 1)
            AST_WRAP_NO_OVF: assert (result == {1'b1, {(W-1){1'b0}}});        // R7
        if (ctl == 6'b000000)
            AST_AND_SUBSET: assert ((result & ~op_x) == '0);                  // R3
    end
endmodule

bind flag_alu alu_props #(.W(W)) u_props (
    .op_x    (op_x),
    .op_y    (op_y),
    .ctl     (ctl),
    .result  (result),
    .is_zero (is_zero),
    .is_neg  (is_neg)
);

// File: tb/sim_flag_alu.sv
module sim_flag_alu;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] op_x = '0, op_y = '0;
    logic [5:0]  ctl  = '0;
    logic [15:0] result;
    logic        is_zero, is_neg;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [15:0] r;
        string       req;
    } exp_t;
    exp_t q[$];

    always #10 clk = ~clk;   // 50 MHz

    flag_alu u0 (
        .op_x(op_x), .op_y(op_y), .ctl(ctl),
        .result(result), .is_zero(is_zero), .is_neg(is_neg)
    );

    // Model written from the requirement text
    function automatic logic [15:0] model(input logic [15:0] x, input logic [15:0] y,
                                          input logic [5:0] c);
        logic [15:0] a, b, v;
        a = c[5] ? 16'h0000 : x;
        a = c[4] ? ~a : a;
        b = c[3] ? 16'h0000 : y;
        b = c[2] ? ~b : b;
        v = c[1] ? 16'(a + b) : (a & b);
        return c[0] ? ~v : v;
    endfunction

    task automatic drive(input logic [15:0] x, input logic [15:0] y,
                         input logic [5:0] c, input logic [15:0] e, input string req);
        exp_t it;
        @(posedge clk);
        op_x = x; op_y = y; ctl = c;
        it.r = e; it.req = req;
        q.push_back(it);
    endtask

    // Monitor: compare away from the active edge
    always @(negedge clk) begin
        if (!rst && q.size() > 0) begin
            exp_t it;
            it = q.pop_front();
            n_chk++;
            if (result !== it.r || is_zero !== (it.r == 16'h0) || is_neg !== it.r[15]) begin
                n_fail++;
                $display("FAIL %s: x=%h y=%h ctl=%b got r=%h z=%b n=%b expected r=%h z=%b n=%b",
                         it.req, op_x, op_y, ctl, result, is_zero, is_neg,
                         it.r, (it.r == 16'h0), it.r[15]);
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [15:0] corners [4];
        corners[0] = 16'h0000; corners[1] = 16'hFFFF;
        corners[2] = 16'h8000; corners[3] = 16'h7FFF;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // Quiescent state: zero inputs, AND function
        drive(16'h0, 16'h0, 6'b000000, 16'h0000, "R6 reset-state");
        // R1 / R2 clear-before-invert
        drive(16'h1234, 16'hABCD, 6'b110000, 16'hABCD, "R1 clr+inv x");
        drive(16'h1234, 16'hABCD, 6'b001100, 16'h1234, "R2 clr+inv y");
        drive(16'h1234, 16'hABCD, 6'b100010, 16'hABCD, "R1 clr x only");
        drive(16'h1234, 16'hABCD, 6'b000110, 16'(16'h1234 + ~16'hABCD), "R2 inv y only");
        // R3 / R4
        drive(16'hF0F0, 16'h3C3C, 6'b000000, 16'h3030, "R3 and");
        drive(16'hF0F0, 16'h3C3C, 6'b000010, 16'h2D2C, "R3 add");
        drive(16'hF0F0, 16'h3C3C, 6'b000001, 16'hCFCF, "R4 inv and");
        // R7 wrap
        drive(16'h7FFF, 16'h0001, 6'b000010, 16'h8000, "R7 pos wrap");
        drive(16'hFFFF, 16'h0001, 6'b000010, 16'h0000, "R7 carry drop");
        drive(16'h8000, 16'h8000, 6'b000010, 16'h0000, "R7 neg wrap");
        // R9 constants
        drive(16'h5A5A, 16'hA5A5, 6'b101010, 16'h0000, "R9 const 0");
        drive(16'h5A5A, 16'hA5A5, 6'b111111, 16'h0001, "R9 const 1");
        drive(16'h5A5A, 16'hA5A5, 6'b111010, 16'hFFFF, "R9 const -1");

        // R8 derived functions over corners and random operands
        for (int i = 0; i < 4 + 200; i++) begin
            logic [15:0] x, y;
            x = (i < 4) ? corners[i] : 16'($urandom);
            for (int j = 0; j < 4; j++) begin
                y = (i < 4) ? corners[j] : 16'($urandom);
                drive(x, y, 6'b000010, 16'(x + y), "R8 x+y");
                drive(x, y, 6'b000000, x & y,       "R8 x&y");
                drive(x, y, 6'b010101, x | y,       "R8 x|y");
                drive(x, y, 6'b001111, 16'(-x),     "R8 -x");
                drive(x, y, 6'b011111, 16'(x + 1),  "R8 x+1");
                drive(x, y, 6'b000111, 16'(y - x),  "R8 y-x");
            end
        end

        // All control words on corners (R1..R7 via model)
        for (int c = 0; c < 64; c++) begin
            for (int i = 0; i < 4; i++) begin
                for (int j = 0; j < 4; j++) begin
                    drive(corners[i], corners[j], 6'(c),
                          model(corners[i], corners[j], 6'(c)), "R1-model sweep");
                end
            end
        end

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule